// File: doc/BRIEF.md
# Time-Triggered Bank-Group DRAM Scheduler

This block drives the command, address and data bus of a two-rank DRAM on behalf of four clients. Each client owns one private group of banks. Groups 0 and 2 sit in rank 0, and groups 1 and 3 sit in rank 1, so neighbouring slots of the rotation always switch rank. A free-running slot counter hands the bus to the groups in the fixed order 0, 1, 2, 3 and then starts over. The rotation never changes, whatever requests are waiting. A slot whose owner has nothing queued stays empty. No other client can take it.

Each client holds at most one outstanding request, accepted with a valid/ready handshake. The request carries a row, a column, a bank-select bit, a write flag and write data. When the owner's slot begins, the block activates the row. A fixed number of cycles later it issues a read or write with auto-precharge, so every access starts from a closed bank. The response pulse comes at a fixed offset from the start of the slot. A client's latency therefore depends only on where its request falls in the rotation, never on the other clients' traffic or on earlier rows.

Top module: `ttbs_top`

## Requirements
- R1: While reset is held, every `req_ready` bit is 1, `dram_cmd` is 0 (no operation) and `rsp_done` is 0.
- R2: After reset is released, the slot of group g begins in cycle 48·k + 12·g (k = 0, 1, ...) with default parameters, counting the first cycle out of reset as cycle 0. An activate (`dram_cmd` = 1) is issued only in the first cycle of a slot, and only when that slot's owner has a request pending.
- R3: A slot whose owner has no pending request at the start of the slot shows `dram_cmd` = 0 in every one of its cycles, even when other groups have requests waiting.
- R4: An activate drives `dram_rank` = g[0], `dram_bank` = {g[1], bank-select bit}, and `dram_addr` = the request row.
- R5: Exactly STEP (default 4) cycles after the activate, the block issues `dram_cmd` = 2 (read with auto-precharge) or 3 (write with auto-precharge) to the same rank and bank. During that command, `dram_addr` carries the column, zero-extended.
- R6: `dram_wen` is 1 only in the cycle of a write command, and in that cycle `dram_wdata` equals the request's write data.
- R7: Read data is sampled RD_LAT (default 4) cycles after the read command. It is returned on the owner's `rsp_rdata` lane with a one-cycle `rsp_done` pulse in slot cycle STEP+RD_LAT+1 (default 9). A write also pulses `rsp_done` at the same offset, with `rsp_rdata` = 0. At most one `rsp_done` bit is high at a time.
- R8: `req_ready[g]` is 1 exactly when group g holds no request. A request is taken at a clock edge where valid and ready are both 1. Ready then stays 0 until the cycle of that request's `rsp_done` pulse, in which it is 1 again.
- R9: A request accepted after its owner's slot has begun is not served in that slot. It is served in the next rotation, with `rsp_done` in cycle 48·(k+1) + 12·g + 9.
- R10: The cycle count from handshake to `rsp_done` for one client is the same whether the other three clients are idle or busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 4 | Request valid, one bit per client |
| req_ready | output | 4 | Request ready, one bit per client |
| req_write | input | 4 | 1 = write, 0 = read, per client |
| req_bsel | input | 4 | Bank-select bit within the client's group |
| req_row | input | 4·ROW_W | Row address, client g in bits [g·ROW_W +: ROW_W] |
| req_col | input | 4·COL_W | Column address, client g in bits [g·COL_W +: COL_W] |
| req_wdata | input | 4·DATA_W | Write data, client g in bits [g·DATA_W +: DATA_W] |
| rsp_done | output | 4 | Completion pulse, one bit per client |
| rsp_rdata | output | 4·DATA_W | Read data lanes, client g in bits [g·DATA_W +: DATA_W] |
| dram_cmd | output | 3 | 0 no-op, 1 activate, 2 read+precharge, 3 write+precharge |
| dram_rank | output | 1 | Rank select |
| dram_bank | output | 2 | Bank within rank |
| dram_addr | output | ROW_W | Row on activate, column on read/write |
| dram_wen | output | 1 | Write data valid |
| dram_wdata | output | DATA_W | Write data |
| dram_rdata | input | DATA_W | Read data from the DRAM |

## Verification
The bench sends each client requests that arrive just after its own slot has begun. A design that squeezed such a request into the slot already under way would issue a column command with no activate before it, or would pulse done a rotation early. Empty slots next to busy ones are watched cycle by cycle. Handing an idle slot to a waiting neighbour would show up as an activate at the wrong moment, and a skewed latency when the other clients are busy. The DRAM model in the bench returns a poison word outside the read-data cycle and stores data by the bus rank, bank, row and column. A design that sampled read data one cycle off, or mapped a group onto the wrong rank or bank, would return data that does not match the bench's own shadow copy.

// File: rtl/ttbs_pkg.sv
package ttbs_pkg;

    localparam int unsigned NGRP  = 4;
    localparam int unsigned GRP_W = 2;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RDA = 3'd2,
        CMD_WRA = 3'd3
    } dcmd_e;

    // Rank follows the low group bit so the rotation alternates ranks.
    function automatic logic grp_rank(input logic [GRP_W-1:0] g);
        return g[0];
    endfunction

    // Each group owns two banks in its rank; the client picks one.
    function automatic logic [1:0] grp_bank(input logic [GRP_W-1:0] g, input logic bsel);
        return {g[1], bsel};
    endfunction

endpackage

// File: rtl/ttbs_slot_timer.sv
module ttbs_slot_timer
    import ttbs_pkg::*;
#(
    parameter int unsigned SLOT_LEN = 12,
    parameter int unsigned STEP     = 4,
    parameter int unsigned RD_LAT   = 4
) (
    input  logic             clk,
    input  logic             rst,
    output logic [GRP_W-1:0] grp,
    output logic             slot_start,
    output logic             cas_tick,
    output logic             cap_tick
);

    localparam int unsigned CNT_W = $clog2(SLOT_LEN);
    localparam int unsigned CAP_O = STEP + RD_LAT;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            grp <= '0;
        end else if (cnt == CNT_W'(SLOT_LEN - 1)) begin
            cnt <= '0;
            grp <= grp + 1'b1;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign slot_start = (cnt == '0);
    assign cas_tick   = (cnt == CNT_W'(STEP));
    assign cap_tick   = (cnt == CNT_W'(CAP_O));

    // R2
    grp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!slot_start) |-> (grp == $past(grp)));

endmodule

// File: rtl/ttbs_req_hold.sv
module ttbs_req_hold #(
    parameter int unsigned ROW_W  = 13,
    parameter int unsigned COL_W  = 10,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              in_write,
    input  logic              in_bsel,
    input  logic [ROW_W-1:0]  in_row,
    input  logic [COL_W-1:0]  in_col,
    input  logic [DATA_W-1:0] in_wdata,
    input  logic              clear,
    output logic              ready,
    output logic              pend,
    output logic              q_write,
    output logic              q_bsel,
    output logic [ROW_W-1:0]  q_row,
    output logic [COL_W-1:0]  q_col,
    output logic [DATA_W-1:0] q_wdata
);

    assign ready = !pend;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend    <= 1'b0;
            q_write <= 1'b0;
            q_bsel  <= 1'b0;
            q_row   <= '0;
            q_col   <= '0;
            q_wdata <= '0;
        end else if (clear) begin
            pend <= 1'b0;
        end else if (in_valid && !pend) begin
            pend    <= 1'b1;
            q_write <= in_write;
            q_bsel  <= in_bsel;
            q_row   <= in_row;
            q_col   <= in_col;
            q_wdata <= in_wdata;
        end
    end

    // R8
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && ready) |=> !ready);

    // R8
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (pend && !clear) |=> ($stable(q_row) && $stable(q_col) && $stable(q_write)));

endmodule

// File: rtl/ttbs_cmd_issue.sv
module ttbs_cmd_issue
    import ttbs_pkg::*;
#(
    parameter int unsigned ROW_W  = 13,
    parameter int unsigned COL_W  = 10,
    parameter int unsigned DATA_W = 32
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [GRP_W-1:0]             grp,
    input  logic                         slot_start,
    input  logic                         cas_tick,
    input  logic                         cap_tick,
    input  logic [NGRP-1:0]              pend,
    input  logic [NGRP-1:0]              q_write,
    input  logic [NGRP-1:0]              q_bsel,
    input  logic [NGRP-1:0][ROW_W-1:0]   q_row,
    input  logic [NGRP-1:0][COL_W-1:0]   q_col,
    input  logic [NGRP-1:0][DATA_W-1:0]  q_wdata,
    input  logic [DATA_W-1:0]            dram_rdata,
    output dcmd_e                        cmd,
    output logic                         rank,
    output logic [1:0]                   bank,
    output logic [ROW_W-1:0]             addr,
    output logic                         wen,
    output logic [DATA_W-1:0]            wdata,
    output logic [NGRP-1:0]              clear,
    output logic [NGRP-1:0]              done,
    output logic [NGRP-1:0][DATA_W-1:0]  rdata
);

    logic       live;
    logic       last_rank;
    logic [1:0] last_bank;

    always_comb begin
        cmd   = CMD_NOP;
        rank  = 1'b0;
        bank  = 2'b00;
        addr  = '0;
        wen   = 1'b0;
        wdata = '0;
        clear = '0;
        if (slot_start && pend[grp]) begin
            cmd  = CMD_ACT;
            rank = grp_rank(grp);
            bank = grp_bank(grp, q_bsel[grp]);
            addr = q_row[grp];
        end else if (cas_tick && live) begin
            cmd  = q_write[grp] ? CMD_WRA : CMD_RDA;
            rank = grp_rank(grp);
            bank = grp_bank(grp, q_bsel[grp]);
            addr[COL_W-1:0] = q_col[grp];
            if (q_write[grp]) begin
                wen   = 1'b1;
                wdata = q_wdata[grp];
            end
        end
        if (cap_tick && live) begin
            clear[grp] = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            live      <= 1'b0;
            done      <= '0;
            rdata     <= '0;
            last_rank <= 1'b0;
            last_bank <= 2'b00;
        end else begin
            done <= clear;
            if (slot_start) begin
                live <= pend[grp];
            end else if (cap_tick) begin
                live <= 1'b0;
            end
            if (cap_tick && live) begin
                rdata[grp] <= q_write[grp] ? '0 : dram_rdata;
            end
            if (cmd == CMD_ACT) begin
                last_rank <= rank;
                last_bank <= bank;
            end
        end
    end

    // R5
    cas_bank_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_RDA || cmd == CMD_WRA) |-> (rank == last_rank && bank == last_bank));

    // R7
    done_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(done));

    // R6
    wen_only_write_chk: assert property (@(posedge clk) disable iff (rst)
        wen |-> (cmd == CMD_WRA));

endmodule

// File: rtl/ttbs_top.sv
module ttbs_top
    import ttbs_pkg::*;
#(
    parameter int unsigned ROW_W    = 13,
    parameter int unsigned COL_W    = 10,
    parameter int unsigned DATA_W   = 32,
    parameter int unsigned STEP     = 4,
    parameter int unsigned RD_LAT   = 4,
    parameter int unsigned SLOT_LEN = 12
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [3:0]             req_valid,
    output logic [3:0]             req_ready,
    input  logic [3:0]             req_write,
    input  logic [3:0]             req_bsel,
    input  logic [4*ROW_W-1:0]     req_row,
    input  logic [4*COL_W-1:0]     req_col,
    input  logic [4*DATA_W-1:0]    req_wdata,
    output logic [3:0]             rsp_done,
    output logic [4*DATA_W-1:0]    rsp_rdata,
    output logic [2:0]             dram_cmd,
    output logic                   dram_rank,
    output logic [1:0]             dram_bank,
    output logic [ROW_W-1:0]       dram_addr,
    output logic                   dram_wen,
    output logic [DATA_W-1:0]      dram_wdata,
    input  logic [DATA_W-1:0]      dram_rdata
);

    logic [GRP_W-1:0]            grp;
    logic                        slot_start;
    logic                        cas_tick;
    logic                        cap_tick;
    logic [NGRP-1:0]             pend;
    logic [NGRP-1:0]             clear;
    logic [NGRP-1:0]             q_write;
    logic [NGRP-1:0]             q_bsel;
    logic [NGRP-1:0][ROW_W-1:0]  q_row;
    logic [NGRP-1:0][COL_W-1:0]  q_col;
    logic [NGRP-1:0][DATA_W-1:0] q_wdata;
    logic [NGRP-1:0][DATA_W-1:0] rdata;
    dcmd_e                       cmd;

    ttbs_slot_timer #(.SLOT_LEN(SLOT_LEN), .STEP(STEP), .RD_LAT(RD_LAT)) u_timer (
        .clk(clk), .rst(rst), .grp(grp), .slot_start(slot_start),
        .cas_tick(cas_tick), .cap_tick(cap_tick)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_hold
        ttbs_req_hold #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_hold (
            .clk(clk), .rst(rst),
            .in_valid(req_valid[g]), .in_write(req_write[g]), .in_bsel(req_bsel[g]),
            .in_row(req_row[g*ROW_W +: ROW_W]), .in_col(req_col[g*COL_W +: COL_W]),
            .in_wdata(req_wdata[g*DATA_W +: DATA_W]),
            .clear(clear[g]), .ready(req_ready[g]), .pend(pend[g]),
            .q_write(q_write[g]), .q_bsel(q_bsel[g]), .q_row(q_row[g]),
            .q_col(q_col[g]), .q_wdata(q_wdata[g])
        );
        assign rsp_rdata[g*DATA_W +: DATA_W] = rdata[g];
    end

    ttbs_cmd_issue #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_issue (
        .clk(clk), .rst(rst), .grp(grp), .slot_start(slot_start),
        .cas_tick(cas_tick), .cap_tick(cap_tick), .pend(pend),
        .q_write(q_write), .q_bsel(q_bsel), .q_row(q_row), .q_col(q_col),
        .q_wdata(q_wdata), .dram_rdata(dram_rdata), .cmd(cmd),
        .rank(dram_rank), .bank(dram_bank), .addr(dram_addr),
        .wen(dram_wen), .wdata(dram_wdata), .clear(clear),
        .done(rsp_done), .rdata(rdata)
    );

    assign dram_cmd = cmd;

    // R2
    act_at_start_chk: assert property (@(posedge clk) disable iff (rst)
        (dram_cmd == 3'd1) |-> slot_start);

    // R8
    done_frees_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_done != 4'b0) |-> ((rsp_done & ~req_ready) == 4'b0));

endmodule

// File: tb/sim_ttbs_top.sv
`timescale 1ns/1ps
module sim_ttbs_top;

    localparam int ROW_W  = 13;
    localparam int COL_W  = 10;
    localparam int DATA_W = 32;
    localparam int STEP   = 4;
    localparam int RD_LAT = 4;
    localparam int SLOT   = 12;
    localparam int PERIOD = 4 * SLOT;
    localparam int DOFS   = STEP + RD_LAT + 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #5 clk = ~clk;

    bit                 b_valid [4];
    bit                 b_write [4];
    bit                 b_bsel  [4];
    logic [ROW_W-1:0]   b_row   [4];
    logic [COL_W-1:0]   b_col   [4];
    logic [DATA_W-1:0]  b_wdata [4];

    logic [3:0]          req_valid, req_write, req_bsel, req_ready, rsp_done;
    logic [4*ROW_W-1:0]  req_row;
    logic [4*COL_W-1:0]  req_col;
    logic [4*DATA_W-1:0] req_wdata, rsp_rdata;
    logic [2:0]          dram_cmd;
    logic                dram_rank, dram_wen;
    logic [1:0]          dram_bank;
    logic [ROW_W-1:0]    dram_addr;
    logic [DATA_W-1:0]   dram_wdata, dram_rdata;

    for (genvar g = 0; g < 4; g++) begin : g_pack
        assign req_valid[g] = b_valid[g];
        assign req_write[g] = b_write[g];
        assign req_bsel[g]  = b_bsel[g];
        assign req_row[g*ROW_W +: ROW_W]    = b_row[g];
        assign req_col[g*COL_W +: COL_W]    = b_col[g];
        assign req_wdata[g*DATA_W +: DATA_W] = b_wdata[g];
    end

    ttbs_top #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .STEP(STEP),
               .RD_LAT(RD_LAT), .SLOT_LEN(SLOT)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_bsel(req_bsel), .req_row(req_row),
        .req_col(req_col), .req_wdata(req_wdata), .rsp_done(rsp_done),
        .rsp_rdata(rsp_rdata), .dram_cmd(dram_cmd), .dram_rank(dram_rank),
        .dram_bank(dram_bank), .dram_addr(dram_addr), .dram_wen(dram_wen),
        .dram_wdata(dram_wdata), .dram_rdata(dram_rdata)
    );

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h", req, what, cyc, act, exp);
        end
    endtask

    function automatic logic [DATA_W-1:0] seed(input int i);
        return 32'h3C00_0000 ^ (i * 32'h0001_9E37);
    endfunction

    // DRAM model, indexed by bus fields
    logic [DATA_W-1:0] mem     [512];
    logic [ROW_W-1:0]  openrow [8];
    logic [DATA_W-1:0] pipe    [RD_LAT];
    logic [8:0]        bidx;
    assign bidx = {dram_rank, dram_bank, openrow[{dram_rank, dram_bank}][2:0], dram_addr[2:0]};
    assign dram_rdata = pipe[RD_LAT-1];

    // shadow memory, indexed by request fields
    logic [DATA_W-1:0] shadow [512];

    initial begin
        for (int i = 0; i < 512; i++) begin
            mem[i]    = seed(i);
            shadow[i] = seed(i);
        end
        for (int i = 0; i < 8; i++) openrow[i] = '0;
        for (int i = 0; i < RD_LAT; i++) pipe[i] = 32'hBAD0_BAD0;
        for (int i = 0; i < 4; i++) begin
            b_valid[i] = 0; b_write[i] = 0; b_bsel[i] = 0;
            b_row[i] = '0; b_col[i] = '0; b_wdata[i] = '0;
        end
    end

    always @(posedge clk) begin
        if (dram_cmd == 3'd1) openrow[{dram_rank, dram_bank}] <= dram_addr;
        if (dram_cmd == 3'd3) mem[bidx] <= dram_wdata;
        pipe[0] <= (dram_cmd == 3'd2) ? mem[bidx] : 32'hBAD0_BAD0;
        for (int k = 1; k < RD_LAT; k++) pipe[k] <= pipe[k-1];
    end

    always @(posedge clk) begin
        if (rst) cyc <= 0;
        else     cyc <= cyc + 1;
    end

    // reference model state
    bit               mpend  [4];
    bit               mw     [4];
    bit               mbs    [4];
    logic [ROW_W-1:0] mrow   [4];
    logic [COL_W-1:0] mcol   [4];
    logic [DATA_W-1:0] mdat  [4];
    bit               slive;
    int               pos, sg, so;
    logic [2:0]       e_cmd;
    logic [3:0]       e_done, e_ready;
    logic [DATA_W-1:0] e_rdata;
    logic [8:0]       sidx;
    string            tag;

    initial for (int i = 0; i < 4; i++) mpend[i] = 0;

    always @(negedge clk) begin
        if (!rst) begin
            pos = cyc % PERIOD;
            sg  = pos / SLOT;
            so  = pos % SLOT;
            e_cmd  = 3'd0;
            e_done = 4'b0;
            if (so == 0) slive = mpend[sg];
            tag = slive ? "R2" : "R3";
            if (so == 0 && slive) begin
                e_cmd = 3'd1;
                tag = "R2";
            end else if (so == STEP && slive) begin
                e_cmd = mw[sg] ? 3'd3 : 3'd2;
                tag = "R5";
            end
            chk(dram_cmd == e_cmd, tag, "command", 64'(dram_cmd), 64'(e_cmd));
            if (e_cmd == 3'd1) begin
                chk(dram_rank == sg[0], "R4", "activate rank", 64'(dram_rank), 64'(sg[0]));
                chk(dram_bank == {sg[1], mbs[sg]}, "R4", "activate bank",
                    64'(dram_bank), 64'({sg[1], mbs[sg]}));
                chk(dram_addr == mrow[sg], "R4", "activate row", 64'(dram_addr), 64'(mrow[sg]));
            end
            if (e_cmd == 3'd2 || e_cmd == 3'd3) begin
                chk(dram_rank == sg[0] && dram_bank == {sg[1], mbs[sg]}, "R5", "cas bank",
                    64'({dram_rank, dram_bank}), 64'({sg[0], sg[1], mbs[sg]}));
                chk(dram_addr == ROW_W'(mcol[sg]), "R5", "cas column",
                    64'(dram_addr), 64'(mcol[sg]));
            end
            chk(dram_wen == (e_cmd == 3'd3), "R6", "write enable",
                64'(dram_wen), 64'(e_cmd == 3'd3));
            if (e_cmd == 3'd3)
                chk(dram_wdata == mdat[sg], "R6", "write data", 64'(dram_wdata), 64'(mdat[sg]));
            if (so == DOFS && slive) begin
                e_done[sg] = 1'b1;
                sidx = {sg[0], sg[1], mbs[sg], mrow[sg][2:0], mcol[sg][2:0]};
                e_rdata = mw[sg] ? '0 : shadow[sidx];
                if (mw[sg]) shadow[sidx] = mdat[sg];
                mpend[sg] = 0;
                slive = 0;
                chk(rsp_rdata[sg*DATA_W +: DATA_W] == e_rdata, "R7", "response data",
                    64'(rsp_rdata[sg*DATA_W +: DATA_W]), 64'(e_rdata));
            end
            chk(rsp_done == e_done, "R7", "done pulse", 64'(rsp_done), 64'(e_done));
            for (int k = 0; k < 4; k++) e_ready[k] = !mpend[k];
            chk(req_ready == e_ready, "R8", "ready", 64'(req_ready), 64'(e_ready));
            for (int k = 0; k < 4; k++) begin
                if (b_valid[k] && !mpend[k]) begin
                    mpend[k] = 1; mw[k] = b_write[k]; mbs[k] = b_bsel[k];
                    mrow[k] = b_row[k]; mcol[k] = b_col[k]; mdat[k] = b_wdata[k];
                end
            end
        end
    end

    task automatic send(input int g, input bit w, input bit bs, input logic [ROW_W-1:0] r,
                        input logic [COL_W-1:0] c, input logic [DATA_W-1:0] d, output int hs);
        @(posedge clk); #1;
        b_valid[g] = 1; b_write[g] = w; b_bsel[g] = bs;
        b_row[g] = r; b_col[g] = c; b_wdata[g] = d;
        do @(negedge clk); while (!req_ready[g]);
        hs = cyc;
        @(posedge clk); #1;
        b_valid[g] = 0;
    endtask

    task automatic wait_done(input int g, output int t);
        do @(negedge clk); while (!rsp_done[g]);
        t = cyc;
    endtask

    task automatic wait_phase(input int ph);
        do @(negedge clk); while ((cyc % PERIOD) != ph);
    endtask

    task automatic summary;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int hs, td, lat_alone, lat_busy, h0, h2, h3;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(req_ready == 4'hF, "R1", "ready in reset", 64'(req_ready), 64'hF);
        chk(dram_cmd == 3'd0, "R1", "cmd in reset", 64'(dram_cmd), 64'd0);
        chk(rsp_done == 4'd0, "R1", "done in reset", 64'(rsp_done), 64'd0);
        @(posedge clk); #1 rst = 0;

        // sweep: per group and bank select, write then read back
        for (int g = 0; g < 4; g++) begin
            for (int bs = 0; bs < 2; bs++) begin
                send(g, 1, bs[0], ROW_W'(13'h100 + g), COL_W'(g + 2*bs),
                     32'hC0DE_0000 + 32'(g*16 + bs), hs);
                send(g, 0, bs[0], ROW_W'(13'h100 + g), COL_W'(g + 2*bs), 32'h0, hs);
            end
        end

        // R9: request arrives after own slot has begun
        wait_phase(1);
        send(0, 0, 1'b0, 13'h5, 10'h3, 32'h0, hs);
        wait_done(0, td);
        chk(td == (hs / PERIOD + 1) * PERIOD + DOFS, "R9", "late request served next rotation",
            64'(td), 64'((hs / PERIOD + 1) * PERIOD + DOFS));

        // R10: latency alone vs with all others busy
        wait_phase(29);
        send(1, 0, 1'b1, 13'h22, 10'h6, 32'h0, hs);
        wait_done(1, td);
        lat_alone = td - hs;
        wait_phase(29);
        fork
            send(1, 0, 1'b1, 13'h23, 10'h7, 32'h0, hs);
            send(0, 1, 1'b0, 13'h31, 10'h1, 32'hAAAA_0000, h0);
            send(2, 0, 1'b1, 13'h32, 10'h2, 32'h0, h2);
            send(3, 1, 1'b0, 13'h33, 10'h4, 32'hBBBB_0000, h3);
        join
        wait_done(1, td);
        lat_busy = td - hs;
        chk(lat_busy == lat_alone, "R10", "latency independent of other clients",
            64'(lat_busy), 64'(lat_alone));

        // concurrent sweep across all clients
        for (int rnd = 0; rnd < 24; rnd++) begin
            fork
                send(0, (rnd % 3) == 0, rnd[0],     ROW_W'(rnd*7),     COL_W'(rnd*3),     32'(rnd*32'h1111), h0);
                send(1, (rnd % 3) == 1, rnd[1],     ROW_W'(rnd*7 + 1), COL_W'(rnd*3 + 5), 32'(rnd*32'h2223), hs);
                send(2, (rnd % 3) == 2, ~rnd[0],    ROW_W'(rnd*5 + 2), COL_W'(rnd + 2),   32'(rnd*32'h3335), h2);
                send(3, (rnd % 2) == 0, rnd[2],     ROW_W'(rnd*3 + 3), COL_W'(rnd*5 + 1), 32'(rnd*32'h4447), h3);
            join
        end
        repeat (3 * PERIOD) @(posedge clk);
        summary();
        $finish;
    end

endmodule